// File: doc/BRIEF.md
# Snooze Low-Power Mode Controller

This controller sits in front of the access logic of a synchronous memory. It manages the way into and out of a low-power snooze state. The snooze request arrives asynchronously and is active high. A two-flop synchroniser brings it into the clock domain. The request must stay high for a programmable number of cycles before the controller goes to sleep. While asleep, the clock keeps running and the stored contents are untouched. Every other input is cut off from the access logic: the gated input bus is forced to zero and both address strobes are dropped.

Wake-up is filtered the same way: the request must stay low for a set number of cycles. The controller then enters a recovery window of a fixed cycle count. During that window the other inputs pass through again, but neither address strobe is forwarded. A strobe dropped during sleep or recovery is discarded and never queued. Three flags report the state: a sleep flag, an input-gate flag and a ready flag. The entry, wake and recovery intervals are parameters in clock cycles. With a 15 ns clock, 7 cycles covers a 100 ns interval.

Top module: `snz_guard_top`

## Requirements
- R1: After reset the controller is awake, with sleepFlag=0, inputGate=1 and readyFlag=1.
- R2: snoozeReq passes through two synchroniser flops. A level first sampled at a rising edge reaches the state logic at the second edge after it.
- R3: From awake, the controller goes to sleep only when the synchronised request has been high for ENTRY_CYC consecutive cycles. sleepFlag rises on the (ENTRY_CYC+2)-th rising edge that samples snoozeReq high. A shorter high pulse leaves the controller awake.
- R4: While asleep, sleepFlag=1 and inputGate=0. accessOut is all zeros whatever accessIn is. Both strobe outputs are 0 whatever the strobe inputs are.
- R5: From asleep, the controller leaves only after the synchronised request has been low for WAKE_CYC consecutive cycles. It then goes to recovering, with sleepFlag=0, inputGate=1 and readyFlag=0. A shorter low pulse keeps it asleep.
- R6: While recovering, both strobe outputs are 0 and accessOut equals accessIn.
- R7: readyFlag rises exactly RECOVER_CYC cycles after recovering was entered. Strobes dropped earlier are not replayed: with both strobe inputs low, the strobe outputs stay 0.
- R8: If the synchronised request is high in any recovering cycle, the controller goes straight back to asleep at that edge.
- R9: While awake, each strobe output equals its strobe input and accessOut equals accessIn, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, kept running during snooze |
| rst_n | input | 1 | Active-low asynchronous reset |
| snoozeReq | input | 1 | Asynchronous snooze request, active high |
| addrStrobeA | input | 1 | First address strobe (processor side) |
| addrStrobeB | input | 1 | Second address strobe (controller side) |
| accessIn | input | IN_W | Other access inputs to be gated |
| addrStrobeAOut | output | 1 | Forwarded first strobe |
| addrStrobeBOut | output | 1 | Forwarded second strobe |
| accessOut | output | IN_W | Gated access inputs, zero while asleep |
| sleepFlag | output | 1 | High while asleep |
| inputGate | output | 1 | High when access inputs pass through |
| readyFlag | output | 1 | High when strobes are honoured |

## Verification
The bench builds the block with ENTRY_CYC=4, WAKE_CYC=3 and RECOVER_CYC=6. Because the three intervals differ, an error that swaps one counter limit for another, or that is off by one, shows up as a flag changing in the wrong cycle. The values also keep the runs short, so one-cycle-too-short pulses can be tried on both entry and wake. The recovery window is longer than the synchroniser delay, so a request that aborts recovery lands well before the window would have expired.

// File: rtl/snz_pkg.sv
package snz_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE      = 2'd0,
    ST_ASLEEP     = 2'd1,
    ST_RECOVERING = 2'd2
  } snzState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic gateOpen;      // pass non-strobe inputs
    logic strobeEnable;  // forward address strobes
    logic sleeping;      // low-power state active
  } snzCtrl_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= asyncIn;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/snz_ctrl.sv
module snz_ctrl
  import snz_pkg::*;
#(
  parameter int ENTRY_CYC   = 7,
  parameter int WAKE_CYC    = 7,
  parameter int RECOVER_CYC = 7
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snoozeReq,
  output snzCtrl_t ctrl
);
  localparam int MAX_CYC = maxOf3(ENTRY_CYC, WAKE_CYC, RECOVER_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ENTRY_LAST   = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST    = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] RECOVER_LAST = CNT_W'(RECOVER_CYC - 1);

  logic             snzSync;
  snzState_e        state;
  logic [CNT_W-1:0] cnt;

  snz_sync #(.STAGES(2)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .asyncIn(snoozeReq),
    .syncOut(snzSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_AWAKE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_AWAKE: begin
          if (!snzSync)                 cnt <= '0;
          else if (cnt == ENTRY_LAST) begin
            state <= ST_ASLEEP;
            cnt   <= '0;
          end else                      cnt <= cnt + 1'b1;
        end
        ST_ASLEEP: begin
          if (snzSync)                  cnt <= '0;
          else if (cnt == WAKE_LAST) begin
            state <= ST_RECOVERING;
            cnt   <= '0;
          end else                      cnt <= cnt + 1'b1;
        end
        ST_RECOVERING: begin
          if (snzSync) begin
            state <= ST_ASLEEP;
            cnt   <= '0;
          end else if (cnt == RECOVER_LAST) begin
            state <= ST_AWAKE;
            cnt   <= '0;
          end else                      cnt <= cnt + 1'b1;
        end
        default: begin
          state <= ST_AWAKE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign ctrl.sleeping     = (state == ST_ASLEEP);
  assign ctrl.gateOpen     = (state != ST_ASLEEP);
  assign ctrl.strobeEnable = (state == ST_AWAKE);

  // Sleep is only reached after the synchronised request was high
  AST_ENTRY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.sleeping) |-> $past(snzSync)); // R3
  // Leaving sleep always passes through recovery first
  AST_WAKE_VIA_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.sleeping) |-> (ctrl.gateOpen && !ctrl.strobeEnable)); // R5
  // Ready only rises out of the recovery window
  AST_READY_FROM_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.strobeEnable) |-> ($past(ctrl.gateOpen) && !$past(snzSync))); // R7
  // Request seen during recovery sends the state back to sleep
  AST_ABORT_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVERING && snzSync) |=> ctrl.sleeping); // R8
endmodule

// File: rtl/snz_datapath.sv
module snz_datapath
  import snz_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  snzCtrl_t        ctrl,
  input  logic            strobeA,
  input  logic            strobeB,
  input  logic [IN_W-1:0] accessIn,
  output logic            strobeAOut,
  output logic            strobeBOut,
  output logic [IN_W-1:0] accessOut
);
  assign strobeAOut = strobeA & ctrl.strobeEnable;
  assign strobeBOut = strobeB & ctrl.strobeEnable;

  generate
    for (genvar b = 0; b < IN_W; b++) begin : g_gate
      assign accessOut[b] = accessIn[b] & ctrl.gateOpen;
    end
  endgenerate

  AST_SLEEP_ZERO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.sleeping |-> (accessOut == '0)); // R4
  AST_NO_STROBE_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.strobeEnable |-> (!strobeAOut && !strobeBOut)); // R6
endmodule

// File: rtl/snz_guard_top.sv
module snz_guard_top
  import snz_pkg::*;
#(
  parameter int ENTRY_CYC   = 7,
  parameter int WAKE_CYC    = 7,
  parameter int RECOVER_CYC = 7,
  parameter int IN_W        = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snoozeReq,
  input  logic            addrStrobeA,
  input  logic            addrStrobeB,
  input  logic [IN_W-1:0] accessIn,
  output logic            addrStrobeAOut,
  output logic            addrStrobeBOut,
  output logic [IN_W-1:0] accessOut,
  output logic            sleepFlag,
  output logic            inputGate,
  output logic            readyFlag
);
  snzCtrl_t ctrl;

  snz_ctrl #(
    .ENTRY_CYC  (ENTRY_CYC),
    .WAKE_CYC   (WAKE_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .snoozeReq(snoozeReq),
    .ctrl     (ctrl)
  );

  snz_datapath #(.IN_W(IN_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .strobeA   (addrStrobeA),
    .strobeB   (addrStrobeB),
    .accessIn  (accessIn),
    .strobeAOut(addrStrobeAOut),
    .strobeBOut(addrStrobeBOut),
    .accessOut (accessOut)
  );

  assign sleepFlag = ctrl.sleeping;
  assign inputGate = ctrl.gateOpen;
  assign readyFlag = ctrl.strobeEnable;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleepFlag, readyFlag}) && (inputGate == !sleepFlag)); // R1
endmodule

// File: tb/snz_guard_top_tb_top.sv
module snz_guard_top_tb_top;
  localparam int ENTRY   = 4;
  localparam int WAKE    = 3;
  localparam int RECOVER = 6;
  localparam int W       = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         snoozeReq = 1'b0;
  logic         stbA = 1'b0, stbB = 1'b0;
  logic [W-1:0] accIn = '0;
  logic         stbAOut, stbBOut, sleepFlag, inputGate, readyFlag;
  logic [W-1:0] accOut;

  int checks = 0;
  int errors = 0;
  int stepNo = 0;

  typedef struct packed {
    logic         sleep;
    logic         gate;
    logic         ready;
    logic         sa;
    logic         sb;
    logic [W-1:0] acc;
    logic [7:0]   req;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;  // 200 MHz

  snz_guard_top #(
    .ENTRY_CYC(ENTRY), .WAKE_CYC(WAKE), .RECOVER_CYC(RECOVER), .IN_W(W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .snoozeReq(snoozeReq),
    .addrStrobeA(stbA), .addrStrobeB(stbB), .accessIn(accIn),
    .addrStrobeAOut(stbAOut), .addrStrobeBOut(stbBOut), .accessOut(accOut),
    .sleepFlag(sleepFlag), .inputGate(inputGate), .readyFlag(readyFlag)
  );

  function automatic void cmp(input logic [W-1:0] act, input logic [W-1:0] exp,
                              input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h (step %0d)", req, what, act, exp, stepNo);
    end
  endfunction

  // Monitor: pops one expectation per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        cmp(W'(sleepFlag), W'(e.sleep), int'(e.req), "sleepFlag");
        cmp(W'(inputGate), W'(e.gate),  int'(e.req), "inputGate");
        cmp(W'(readyFlag), W'(e.ready), int'(e.req), "readyFlag");
        cmp(W'(stbAOut),   W'(e.sa),    int'(e.req), "strobeA out");
        cmp(W'(stbBOut),   W'(e.sb),    int'(e.req), "strobeB out");
        cmp(accOut,        e.acc,       int'(e.req), "accessOut");
      end
    end
  end

  // Driver: drive one cycle of inputs and push what must be seen after the edge
  task automatic step(input logic snz, input logic a, input logic b,
                      input logic expSleep, input logic expReady, input int req);
    expItem_t e;
    @(negedge clk);
    stepNo++;
    snoozeReq = snz;
    stbA      = a;
    stbB      = b;
    accIn     = 32'hC3A5_0000 ^ W'(stepNo * 32'h0001_0F1F);
    e.sleep = expSleep;
    e.gate  = !expSleep;
    e.ready = expReady;
    e.sa    = a & expReady;
    e.sb    = b & expReady;
    e.acc   = expSleep ? '0 : accIn;
    e.req   = 8'(req);
    expQ.push_back(e);
  endtask

  task automatic enterSleep();
    // R2, R3: awake for ENTRY+1 edges, asleep on edge ENTRY+2
    for (int i = 0; i < ENTRY + 1; i++) step(1'b1, i[0], !i[0], 1'b0, 1'b1, 3);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3);
  endtask

  task automatic wakeToRecovery();
    // R5: asleep for WAKE+1 edges, recovering on edge WAKE+2
    for (int i = 0; i < WAKE + 1; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is held
    cmp(W'(sleepFlag), W'(1'b0), 1, "reset sleepFlag");
    cmp(W'(inputGate), W'(1'b1), 1, "reset inputGate");
    cmp(W'(readyFlag), W'(1'b1), 1, "reset readyFlag");
    rst_n = 1'b1;

    // R9: awake pass-through with several strobe patterns
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 9);

    // R3: high pulse one cycle too short keeps the block awake
    for (int i = 0; i < ENTRY - 1; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3);
    for (int i = 0; i < 4; i++)         step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3);

    enterSleep();

    // R4: asleep, everything else is blocked
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4);

    // R5: low pulse one cycle too short keeps it asleep
    for (int i = 0; i < WAKE - 1; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5);
    for (int i = 0; i < 3; i++)        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5);

    wakeToRecovery();

    // R6: recovery window drops strobes, passes other inputs
    for (int i = 0; i < RECOVER - 1; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6);
    // R7: ready exactly RECOVER cycles later, nothing replayed
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 7);

    // R8: request during recovery returns to sleep
    enterSleep();
    wakeToRecovery();
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule